// File: doc/BRIEF.md
# Reset and Configuration Sequencer

This block brings a chip out of power-on reset in a fixed order. While the external power-on reset input is low it holds the internal power-on, hard and soft resets and keeps the internal clocks gated. When power-on reset is released, it reads a source strap. In master mode it takes its built-in configuration word at once. In slave mode it waits for a host to write the word, and falls back to the built-in word if no write arrives in time. The clock-mode pins and the top field of the configuration word are captured together to set up the system PLL.

The block then waits for PLL lock by counting pulses of the PLL reference tick. When the count completes, it enables the clocks, drops internal power-on reset and samples the debug strap. It releases hard reset and then soft reset after fixed delays. After clocks are running, an external hard reset restarts only the hard and soft phases. An external soft reset pulses only the internal soft reset. A sticky cause register records which kinds of reset have occurred since the last power-on.

States: `ST_POR` (power-on held; first clock after release picks the source), `ST_CFG` (slave wait for host word), `ST_LOCK` (lock count), `ST_HARD` (clocks on, hard held), `ST_SOFT` (soft trailing hard), `ST_SPULSE` (external soft pulse), `ST_RUN` (all released). Transitions:
- POR to LOCK when the master strap is set, otherwise POR to CFG.
- CFG to LOCK on a host write or on timeout.
- LOCK to HARD on the final lock tick.
- HARD to SOFT after HARD_HOLD cycles.
- SOFT to RUN after SOFT_LAG cycles.
- RUN to SPULSE on external soft reset, and SPULSE back to RUN once the minimum width has passed and the request is gone.
- HARD, SOFT, SPULSE and RUN all go to HARD on an external hard reset.

Top module: `rstseq_top`

## Requirements
- R1: While `ext_por_n` is low, `int_por`, `int_hard` and `int_soft` are 1 and `clk_en` is 0. This holds from the instant it goes low, without waiting for a clock edge.
- R2: The source strap is read on the first clock edge after `ext_por_n` rises. With `strap_master`=1, `cfg_word` becomes `DEFAULT_CFG` on that edge, and host writes are ignored.
- R3: With `strap_master`=0, the first `host_wr` pulse after release loads `host_data` into `cfg_word`. Any later write leaves `cfg_word` unchanged. Until the word is taken, `cfg_word` reads 0.
- R4: With `strap_master`=0 and no write, `cfg_word` becomes `DEFAULT_CFG` on clock edge HOST_TIMEOUT+1 after release, and reads 0 after edge HOST_TIMEOUT.
- R5: `pll_mode` = {`cfg_word`[CFG_W-1 -: MODEH_W], `clkmode_pins`}. It is captured on the edge that takes the configuration word and does not follow later pin changes.
- R6: `clk_en` rises and `int_por` falls on the clock edge that sees the LOCK_TICKS-th `ref_tick` pulse after configuration. External hard and soft resets during the lock wait are ignored.
- R7: `dbg_boot` takes `strap_dbg` on that same lock-completion edge. Values of the strap at any other time are ignored.
- R8: After `clk_en` rises, `int_hard` stays 1 for exactly HARD_HOLD cycles. `int_soft` stays 1 for exactly SOFT_LAG further cycles, and `int_hard`=1 always implies `int_soft`=1.
- R9: `ext_hard_n` low while `clk_en`=1 restarts the hard phase: `int_hard` is held for HARD_HOLD cycles counted from the latest request, followed by SOFT_LAG cycles of soft reset. `clk_en`, `int_por`, `cfg_word`, `pll_mode` and `dbg_boot` are unchanged.
- R10: `ext_soft_n` low with all resets released asserts only `int_soft`. It stays high for max(SOFT_PULSE, request length) cycles.
- R11: `reset_cause` bit 0 marks power-on, bit 1 marks hard, and bit 2 marks soft. Bits are set by accepted events and never clear. Only power-on reset returns the register to 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| ext_por_n | input | 1 | External power-on reset, active low, asynchronous |
| ext_hard_n | input | 1 | External hard reset request, active low, synchronous |
| ext_soft_n | input | 1 | External soft reset request, active low, synchronous |
| ref_tick | input | 1 | One-cycle pulse per PLL reference clock period |
| strap_master | input | 1 | Configuration source strap: 1 built-in word, 0 host word |
| strap_dbg | input | 1 | Boot-into-debug strap, read at lock |
| clkmode_pins | input | MODE_W | Clock-mode strap pins |
| host_wr | input | 1 | Host configuration write strobe |
| host_data | input | CFG_W | Host configuration word |
| int_por | output | 1 | Internal power-on reset |
| int_hard | output | 1 | Internal hard reset |
| int_soft | output | 1 | Internal soft reset |
| clk_en | output | 1 | Internal clock enable |
| cfg_word | output | CFG_W | Selected configuration word |
| pll_mode | output | MODEH_W+MODE_W | System PLL mode setting |
| dbg_boot | output | 1 | Core starts in debug mode when 1 |
| reset_cause | output | 3 | Sticky reset cause, {soft, hard, power-on} |

## Verification
The bench keeps LOCK_TICKS at 800 and drives one reference tick every four clocks, so each lock wait is checked to the exact pulse count in about 3200 cycles. HOST_TIMEOUT is reduced to 20, which makes the edge-exact timeout boundary and the slave fallback cheap to reach. HARD_HOLD=6, SOFT_LAG=3 and SOFT_PULSE=5 are small and distinct. With these values, a hard-reset restart inside the hard phase, and a soft request held longer than the minimum, each give a width that cannot match any of the other constants by accident.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_POR    = 3'd0,
        ST_CFG    = 3'd1,
        ST_LOCK   = 3'd2,
        ST_HARD   = 3'd3,
        ST_SOFT   = 3'd4,
        ST_SPULSE = 3'd5,
        ST_RUN    = 3'd6
    } rst_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rstseq_cnt.sv
module rstseq_cnt #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    // Saturating up-counter shared by every timed phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc && !(&value)) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/rstseq_cfg.sv
module rstseq_cfg
    import rstseq_pkg::*;
#(
    parameter int unsigned     CFG_W       = 16,
    parameter int unsigned     MODE_W      = 3,
    parameter int unsigned     MODEH_W     = 2,
    parameter logic [CFG_W-1:0] DEFAULT_CFG = 16'h4E21
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  rst_state_e                st,
    input  logic                      timeout,
    input  logic                      lock_done,
    input  logic                      strap_master,
    input  logic                      strap_dbg,
    input  logic [MODE_W-1:0]         clkmode_pins,
    input  logic                      host_wr,
    input  logic [CFG_W-1:0]          host_data,
    output logic                      cfg_load,
    output logic [CFG_W-1:0]          cfg_word,
    output logic [MODEH_W+MODE_W-1:0] pll_mode,
    output logic                      dbg_boot
);

    logic             take_host;
    logic             take_dflt;
    logic [CFG_W-1:0] new_word;

    always_comb begin
        take_host = (st == ST_CFG) && host_wr;
        take_dflt = ((st == ST_POR) && strap_master) ||
                    ((st == ST_CFG) && timeout);
        cfg_load  = take_host || take_dflt;
        new_word  = take_host ? host_data : DEFAULT_CFG;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_word <= '0;
            pll_mode <= '0;
            dbg_boot <= 1'b0;
        end else begin
            if (cfg_load) begin
                cfg_word <= new_word;
                pll_mode <= {new_word[CFG_W-1 -: MODEH_W], clkmode_pins};
            end
            if (lock_done) begin
                dbg_boot <= strap_dbg;
            end
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_POR && st != ST_CFG) |=> ($stable(cfg_word) && $stable(pll_mode))); // R3

    AST_DBG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HARD || st == ST_SOFT || st == ST_SPULSE || st == ST_RUN) |=> $stable(dbg_boot)); // R7

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int unsigned LOCK_TICKS   = 800,
    parameter int unsigned HOST_TIMEOUT = 1024,
    parameter int unsigned HARD_HOLD    = 32,
    parameter int unsigned SOFT_LAG     = 8,
    parameter int unsigned SOFT_PULSE   = 16,
    parameter int unsigned CNT_W        = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hard_req,
    input  logic             soft_req,
    input  logic             ref_tick,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] cnt,
    output rst_state_e       st,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             timeout,
    output logic             lock_done,
    output logic             int_por,
    output logic             int_hard,
    output logic             int_soft,
    output logic             clk_en,
    output logic [2:0]       cause
);

    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_TICKS - 1);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(HOST_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] HARD_LAST = CNT_W'(HARD_HOLD - 1);
    localparam logic [CNT_W-1:0] SOFT_LAST = CNT_W'(SOFT_LAG - 1);
    localparam logic [CNT_W-1:0] PULS_LAST = CNT_W'(SOFT_PULSE - 1);

    rst_state_e nxt;
    logic       hard_restart;

    always_comb begin
        hard_restart = hard_req && (st == ST_HARD || st == ST_SOFT ||
                                    st == ST_SPULSE || st == ST_RUN);
        timeout   = (st == ST_CFG) && (cnt == TMO_LAST);
        lock_done = (st == ST_LOCK) && ref_tick && (cnt == LOCK_LAST);
        nxt = st;
        unique case (st)
            ST_POR:    nxt = cfg_load ? ST_LOCK : ST_CFG;
            ST_CFG:    if (cfg_load) nxt = ST_LOCK;
            ST_LOCK:   if (lock_done) nxt = ST_HARD;
            ST_HARD:   if (hard_restart) nxt = ST_HARD;
                       else if (cnt == HARD_LAST) nxt = ST_SOFT;
            ST_SOFT:   if (hard_restart) nxt = ST_HARD;
                       else if (cnt == SOFT_LAST) nxt = ST_RUN;
            ST_SPULSE: if (hard_restart) nxt = ST_HARD;
                       else if (cnt >= PULS_LAST && !soft_req) nxt = ST_RUN;
            ST_RUN:    if (hard_restart) nxt = ST_HARD;
                       else if (soft_req) nxt = ST_SPULSE;
            default:   nxt = ST_POR;
        endcase
        cnt_clr = (nxt != st) || hard_restart;
        cnt_inc = (st == ST_LOCK) ? ref_tick : 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_POR;
        else        st <= nxt;
    end

    // Sticky cause: bit0 power-on, bit1 hard, bit2 soft
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause <= 3'b001;
        end else begin
            if (hard_restart)                 cause[1] <= 1'b1;
            if (st == ST_RUN && !hard_restart && soft_req) cause[2] <= 1'b1;
        end
    end

    // Output decode
    always_comb begin
        int_por = 1'b0; int_hard = 1'b0; int_soft = 1'b0; clk_en = 1'b1;
        unique case (st)
            ST_POR, ST_CFG, ST_LOCK: begin
                int_por = 1'b1; int_hard = 1'b1; int_soft = 1'b1; clk_en = 1'b0;
            end
            ST_HARD:           begin int_hard = 1'b1; int_soft = 1'b1; end
            ST_SOFT, ST_SPULSE: int_soft = 1'b1;
            ST_RUN:            int_soft = 1'b0;
            default: begin
                int_por = 1'b1; int_hard = 1'b1; int_soft = 1'b1; clk_en = 1'b0;
            end
        endcase
    end

    AST_CLKEN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> $past(ref_tick)); // R6

    AST_POR_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !int_por |-> clk_en); // R6

    AST_HARD_WITH_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        int_hard |-> int_soft); // R8

    AST_HARD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && hard_req) |=> (int_hard && clk_en)); // R9

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause & $past(cause)) == $past(cause))); // R11

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned      CFG_W        = 16,
    parameter int unsigned      MODE_W       = 3,
    parameter int unsigned      MODEH_W      = 2,
    parameter logic [CFG_W-1:0] DEFAULT_CFG  = 16'h4E21,
    parameter int unsigned      LOCK_TICKS   = 800,
    parameter int unsigned      HOST_TIMEOUT = 1024,
    parameter int unsigned      HARD_HOLD    = 32,
    parameter int unsigned      SOFT_LAG     = 8,
    parameter int unsigned      SOFT_PULSE   = 16
) (
    input  logic                      clk,
    input  logic                      ext_por_n,
    input  logic                      ext_hard_n,
    input  logic                      ext_soft_n,
    input  logic                      ref_tick,
    input  logic                      strap_master,
    input  logic                      strap_dbg,
    input  logic [MODE_W-1:0]         clkmode_pins,
    input  logic                      host_wr,
    input  logic [CFG_W-1:0]          host_data,
    output logic                      int_por,
    output logic                      int_hard,
    output logic                      int_soft,
    output logic                      clk_en,
    output logic [CFG_W-1:0]          cfg_word,
    output logic [MODEH_W+MODE_W-1:0] pll_mode,
    output logic                      dbg_boot,
    output logic [2:0]                reset_cause
);

    localparam int unsigned CNT_MAX = max2(max2(LOCK_TICKS, HOST_TIMEOUT),
                                           max2(HARD_HOLD, max2(SOFT_LAG, SOFT_PULSE)));
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    rst_state_e       st;
    logic             cnt_clr, cnt_inc, timeout, lock_done, cfg_load;
    logic [CNT_W-1:0] cnt;

    rstseq_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (ext_por_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .value (cnt)
    );

    rstseq_fsm #(
        .LOCK_TICKS   (LOCK_TICKS),
        .HOST_TIMEOUT (HOST_TIMEOUT),
        .HARD_HOLD    (HARD_HOLD),
        .SOFT_LAG     (SOFT_LAG),
        .SOFT_PULSE   (SOFT_PULSE),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (ext_por_n),
        .hard_req  (!ext_hard_n),
        .soft_req  (!ext_soft_n),
        .ref_tick  (ref_tick),
        .cfg_load  (cfg_load),
        .cnt       (cnt),
        .st        (st),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .timeout   (timeout),
        .lock_done (lock_done),
        .int_por   (int_por),
        .int_hard  (int_hard),
        .int_soft  (int_soft),
        .clk_en    (clk_en),
        .cause     (reset_cause)
    );

    rstseq_cfg #(
        .CFG_W       (CFG_W),
        .MODE_W      (MODE_W),
        .MODEH_W     (MODEH_W),
        .DEFAULT_CFG (DEFAULT_CFG)
    ) u_cfg (
        .clk          (clk),
        .rst_n        (ext_por_n),
        .st           (st),
        .timeout      (timeout),
        .lock_done    (lock_done),
        .strap_master (strap_master),
        .strap_dbg    (strap_dbg),
        .clkmode_pins (clkmode_pins),
        .host_wr      (host_wr),
        .host_data    (host_data),
        .cfg_load     (cfg_load),
        .cfg_word     (cfg_word),
        .pll_mode     (pll_mode),
        .dbg_boot     (dbg_boot)
    );

endmodule

// File: tb/rstseq_top_tb_top.sv
`timescale 1ns/1ps
module rstseq_top_tb_top;

    localparam int          HT   = 20;
    localparam int          HH   = 6;
    localparam int          SL   = 3;
    localparam int          SP   = 5;
    localparam int          LT   = 800;
    localparam logic [15:0] DFLT = 16'h4E21;

    // {master, wr, data[16], pins[3], dbg, exp_cfg[16], exp_mode[5], exp_dbg}
    localparam logic [43:0] VECS [4] = '{
        {1'b1, 1'b0, 16'h0000, 3'b011, 1'b0, 16'h4E21, 5'b01011, 1'b0},
        {1'b0, 1'b1, 16'hA5C3, 3'b101, 1'b1, 16'hA5C3, 5'b10101, 1'b1},
        {1'b0, 1'b0, 16'h0000, 3'b110, 1'b0, 16'h4E21, 5'b01110, 1'b0},
        {1'b1, 1'b1, 16'hFFFF, 3'b000, 1'b1, 16'h4E21, 5'b01000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        ext_por_n = 1'b0, ext_hard_n = 1'b1, ext_soft_n = 1'b1;
    logic        ref_tick = 1'b0, strap_master = 1'b1, strap_dbg = 1'b0;
    logic [2:0]  clkmode_pins = '0;
    logic        host_wr = 1'b0;
    logic [15:0] host_data = '0;
    logic        int_por, int_hard, int_soft, clk_en, dbg_boot;
    logic [15:0] cfg_word;
    logic [4:0]  pll_mode;
    logic [2:0]  reset_cause;

    logic        tick_en = 1'b0;
    int          tick_div = 0;
    int          tick_cnt = 0;
    int          nchk = 0;
    int          nfail = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    rstseq_top #(
        .CFG_W(16), .MODE_W(3), .MODEH_W(2), .DEFAULT_CFG(DFLT),
        .LOCK_TICKS(LT), .HOST_TIMEOUT(HT), .HARD_HOLD(HH),
        .SOFT_LAG(SL), .SOFT_PULSE(SP)
    ) dut_i (
        .clk(clk), .ext_por_n(ext_por_n), .ext_hard_n(ext_hard_n),
        .ext_soft_n(ext_soft_n), .ref_tick(ref_tick), .strap_master(strap_master),
        .strap_dbg(strap_dbg), .clkmode_pins(clkmode_pins), .host_wr(host_wr),
        .host_data(host_data), .int_por(int_por), .int_hard(int_hard),
        .int_soft(int_soft), .clk_en(clk_en), .cfg_word(cfg_word),
        .pll_mode(pll_mode), .dbg_boot(dbg_boot), .reset_cause(reset_cause)
    );

    // Reference tick: one pulse every four clocks, counted as issued
    always @(negedge clk) begin
        if (!tick_en) begin
            tick_div <= 0; tick_cnt <= 0; ref_tick <= 1'b0;
        end else begin
            tick_div <= (tick_div + 1) % 4;
            ref_tick <= (tick_div == 3);
            if (tick_div == 3) tick_cnt <= tick_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            nfail = nfail + 1;
            $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic nx();
        @(negedge clk);
        #1;
    endtask

    initial begin
        int w;
        int hw;
        logic hard_seen;
        logic [15:0] keep_cfg;
        logic [4:0]  keep_mode;
        logic        keep_dbg;

        for (int i = 0; i < 4; i++) begin
            logic [43:0] v;
            string cfg_tag;
            v = VECS[i];
            cfg_tag = v[43] ? "R2" : (v[42] ? "R3" : "R4");
            ext_por_n = 1'b0; tick_en = 1'b0;
            strap_master = v[43]; clkmode_pins = v[25:23]; strap_dbg = ~v[22];
            host_wr = 1'b0; ext_hard_n = 1'b1; ext_soft_n = 1'b1;
            repeat (3) nx();
            chk("R1", {int_por, int_hard, int_soft, clk_en}, 4'b1110);
            chk("R11", reset_cause, 3'b001);
            ext_por_n = 1'b1;
            nx();
            if (v[42]) begin
                nx(); nx();
                host_wr = 1'b1; host_data = v[41:26];
                nx();
                host_wr = 1'b0;
            end else if (!v[43]) begin
                repeat (HT + 4) nx();
            end
            strap_dbg = v[22];
            tick_en = 1'b1;
            repeat (200) nx();
            ext_hard_n = 1'b0; nx(); ext_hard_n = 1'b1;
            ext_soft_n = 1'b0; nx(); ext_soft_n = 1'b1;
            w = 0;
            while (!clk_en && w < 5000) begin w++; nx(); end
            chk("R6", tick_cnt, LT);
            chk("R6", int_por, 1'b0);
            chk("R8", int_hard, 1'b1);
            chk(cfg_tag, cfg_word, v[21:6]);
            chk("R5", pll_mode, v[5:1]);
            chk("R7", dbg_boot, v[0]);
            hw = 0;
            while (int_hard && hw < 100) begin hw++; nx(); end
            chk("R8", hw, HH);
            w = 0;
            while (int_soft && w < 100) begin w++; nx(); end
            chk("R8", w, SL);
            tick_en = 1'b0;
            clkmode_pins = ~v[25:23]; strap_dbg = ~v[22];
            host_wr = 1'b1; host_data = ~v[41:26];
            nx();
            host_wr = 1'b0;
            nx();
            chk("R3", cfg_word, v[21:6]);
            chk("R5", pll_mode, v[5:1]);
            chk("R7", dbg_boot, v[0]);
            chk("R6", reset_cause, 3'b001);
        end

        keep_cfg = cfg_word; keep_mode = pll_mode; keep_dbg = dbg_boot;

        // R10: single-cycle soft request
        ext_soft_n = 1'b0; nx(); ext_soft_n = 1'b1;
        w = 0; hard_seen = 1'b0;
        while (int_soft && w < 100) begin
            w++; hard_seen = hard_seen | int_hard | int_por | !clk_en; nx();
        end
        chk("R10", w, SP);
        chk("R10", hard_seen, 1'b0);
        chk("R11", reset_cause, 3'b101);

        // R10: soft request held past the minimum width
        ext_soft_n = 1'b0; nx();
        w = 0;
        while (int_soft && w < 100) begin
            w++;
            if (w == SP + 4) ext_soft_n = 1'b1;
            nx();
        end
        chk("R10", w, SP + 4);

        // R9: hard request after clocks run
        clkmode_pins = 3'b111; strap_dbg = ~keep_dbg;
        ext_hard_n = 1'b0; nx(); ext_hard_n = 1'b1;
        hw = 0; hard_seen = 1'b0;
        while (int_hard && hw < 100) begin
            hw++; hard_seen = hard_seen | int_por | !clk_en; nx();
        end
        chk("R9", hw, HH);
        chk("R9", hard_seen, 1'b0);
        w = 0;
        while (int_soft && w < 100) begin w++; nx(); end
        chk("R9", w, SL);
        chk("R9", {cfg_word, pll_mode, dbg_boot}, {keep_cfg, keep_mode, keep_dbg});
        chk("R11", reset_cause, 3'b111);

        // R9: second request inside the hard phase restarts the hold
        ext_hard_n = 1'b0; nx(); ext_hard_n = 1'b1;
        hw = 0;
        while (int_hard && hw < 100) begin
            hw++;
            ext_hard_n = (hw == 3) ? 1'b0 : 1'b1;
            nx();
        end
        ext_hard_n = 1'b1;
        chk("R9", hw, 3 + HH);

        // R1: asynchronous assertion mid-run, then R11 clear
        repeat (SL + 2) nx();
        ext_por_n = 1'b0;
        #1;
        chk("R1", {int_por, int_hard, int_soft, clk_en}, 4'b1110);
        chk("R11", reset_cause, 3'b001);

        // R4: timeout boundary in slave mode
        strap_master = 1'b0;
        repeat (2) nx();
        ext_por_n = 1'b1;
        for (int k = 1; k <= HT + 1; k++) begin
            nx();
            if (k == HT)     chk("R4", cfg_word, 16'h0000);
            if (k == HT + 1) chk("R4", cfg_word, DFLT);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule